// File: doc/BRIEF.md
# Line-Buffered Log Capture Buffer

This block gathers text bytes that software writes one at a time and releases them as whole messages. Each accepted byte is stored in a byte buffer at a running offset. A newline byte ends the current line. A byte that arrives when only one free slot is left also ends the line. In either case the triggering byte is dropped, a zero byte is written at the current offset, and the buffer from offset zero up to and including that zero is streamed out.

The output is a byte stream with a valid/ready handshake. The first byte of each message carries a start marker, and the zero terminator carries an end marker. While a message is streaming, the input side is held off by dropping its ready signal, so a writer that keeps its byte valid loses nothing. Once the terminator has been taken, the offset returns to zero and input is accepted again. A synchronous reset clears the offset and drops any message that is still streaming.

Top module: `logbuf_capture`

## Requirements
- R1: After reset, outValid is 0, inReady is 1 and the write offset is 0.
- R2: A byte accepted (inValid and inReady high at a clock edge) that is not a trigger is stored at the current offset, and the offset then increments. Stored bytes come out in the order they were accepted.
- R3: An accepted newline byte (value 0x0A) starts a flush and is not itself emitted. A line of N stored bytes yields N+1 output bytes.
- R4: A byte accepted while the offset equals DEPTH-1 starts a flush and is discarded. The message then holds DEPTH-1 data bytes plus the terminator, DEPTH bytes in all.
- R5: Every message ends with a byte of value 0 with outLast set. outFirst is set only on the byte held at offset 0.
- R6: While outValid is high and outReady is low, outData, outFirst and outLast hold their values. The next byte is presented only after a handshake.
- R7: While a message is streaming, inReady is 0. A byte that the writer keeps valid during that time is accepted afterwards and is not lost.
- R8: A newline accepted at offset 0 produces a message of one byte: the terminator, with both outFirst and outLast set.
- R9: After the terminator handshake, the block accepts input again, and the next message starts from offset 0.
- R10: Synchronous reset during a flush stops streaming in the following cycle and clears the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte strobe |
| inData | input | DATA_W | Input byte |
| inReady | output | 1 | Block can take an input byte |
| outValid | output | 1 | Output byte is valid |
| outReady | input | 1 | Sink takes the output byte |
| outData | output | DATA_W | Output byte |
| outFirst | output | 1 | Marks the first byte of a message |
| outLast | output | 1 | Marks the zero terminator |

## Verification
The bench builds the block with DEPTH set to 16 and DATA_W set to 8. The small depth lets the full-buffer flush of R4 be reached with fifteen stored bytes, and lets a second line follow it straight away to show the offset was cleared. At this depth the sink's backpressure pattern can stall every part of a message, including its first byte and its terminator. The width stays at 8 so the newline and zero values keep their usual meaning.

// File: rtl/logbuf_pkg.sv
package logbuf_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_STREAM  = 1'b1
  } logState_t;

  typedef struct packed {
    logic storeEn;   // write input byte at offset, advance offset
    logic termEn;    // write zero at offset, begin streaming
    logic advRd;     // move read pointer to next byte
    logic endFlush;  // terminator taken: clear pointers
  } logStrb_t;

endpackage

// File: rtl/logbuf_datapath.sv
module logbuf_datapath
  import logbuf_pkg::*;
#(
  parameter int unsigned DEPTH   = 4096,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NEWLINE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logStrb_t          strb,
  output logic              trigHit,
  output logic              lastRd,
  output logic [DATA_W-1:0] outData,
  output logic              outFirst
);

  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH - 1);
  localparam logic [DATA_W-1:0] NL_CODE = DATA_W'(NEWLINE);

  logic [DATA_W-1:0] bufMem [DEPTH];
  logic [ADDR_W-1:0] wrOff;
  logic [ADDR_W-1:0] rdPtr;

  // flush condition for the byte on the input
  assign trigHit = (inData == NL_CODE) || (wrOff == LIMIT);

  // write side: data byte or terminator land at the current offset
  always_ff @(posedge clk) begin
    if (strb.storeEn) begin
      bufMem[wrOff] <= inData;
    end else if (strb.termEn) begin
      bufMem[wrOff] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrOff <= '0;
    end else if (strb.endFlush) begin
      wrOff <= '0;
    end else if (strb.storeEn) begin
      wrOff <= wrOff + 1'b1;
    end
  end

  // read side
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
    end else if (strb.endFlush) begin
      rdPtr <= '0;
    end else if (strb.advRd) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  assign outData  = bufMem[rdPtr];
  assign lastRd   = (rdPtr == wrOff);
  assign outFirst = (rdPtr == '0);

endmodule

// File: rtl/logbuf_ctrl.sv
module logbuf_ctrl
  import logbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     outReady,
  input  logic     trigHit,
  input  logic     lastRd,
  output logic     inReady,
  output logic     outValid,
  output logStrb_t strb
);

  logState_t state, stateNxt;
  logic accept;
  logic pop;

  assign inReady  = (state == ST_COLLECT);
  assign outValid = (state == ST_STREAM);

  assign accept = inValid && inReady;
  assign pop    = outValid && outReady;

  always_comb begin
    strb          = '0;
    strb.storeEn  = accept && !trigHit;
    strb.termEn   = accept && trigHit;
    strb.advRd    = pop && !lastRd;
    strb.endFlush = pop && lastRd;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_COLLECT: if (strb.termEn)   stateNxt = ST_STREAM;
      ST_STREAM:  if (strb.endFlush) stateNxt = ST_COLLECT;
      default:                       stateNxt = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_COLLECT;
    else     state <= stateNxt;
  end

endmodule

// File: rtl/logbuf_capture.sv
module logbuf_capture
  import logbuf_pkg::*;
#(
  parameter int unsigned DEPTH   = 4096,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NEWLINE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outFirst,
  output logic              outLast
);

  logStrb_t strb;
  logic     trigHit;

  logbuf_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .trigHit  (trigHit),
    .lastRd   (outLast),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  logbuf_datapath #(
    .DEPTH   (DEPTH),
    .DATA_W  (DATA_W),
    .NEWLINE (NEWLINE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inData   (inData),
    .strb     (strb),
    .trigHit  (trigHit),
    .lastRd   (outLast),
    .outData  (outData),
    .outFirst (outFirst)
  );

endmodule

// File: rtl/logbuf_checker.sv
module logbuf_checker #(
  parameter int unsigned DEPTH   = 4096,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NEWLINE = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outFirst,
  input logic              outLast
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH - 1);
  localparam logic [DATA_W-1:0] NL_CODE = DATA_W'(NEWLINE);

  logic [CNT_W-1:0] fillCnt;
  logic             acc;

  assign acc = inValid && inReady;

  // independent count of stored bytes seen at the ports
  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (acc) begin
      if (inData == NL_CODE || fillCnt == LIMIT) fillCnt <= '0;
      else                                       fillCnt <= fillCnt + 1'b1;
    end
  end

  p_reset_r10: assert property (@(posedge clk)
    rst |=> !outValid && inReady);

  p_newline_r3: assert property (@(posedge clk) disable iff (rst)
    acc && inData == NL_CODE |=> outValid && outFirst);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    acc && fillCnt == LIMIT |=> outValid && outFirst);

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fillCnt <= LIMIT);

  p_term_zero_r5: assert property (@(posedge clk) disable iff (rst)
    outValid && outLast |-> outData == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData)
                              && $stable(outFirst) && $stable(outLast));

  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && outLast |=> !outValid && inReady);

endmodule

bind logbuf_capture logbuf_checker #(
  .DEPTH   (DEPTH),
  .DATA_W  (DATA_W),
  .NEWLINE (NEWLINE)
) u_chk (.*);

// File: tb/test_logbuf_capture.sv
module test_logbuf_capture;

  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam logic [7:0] NL = 8'h0A;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic             inReady;
  logic             outValid;
  logic             outReady = 1'b1;
  logic [DATA_W-1:0] outData;
  logic             outFirst;
  logic             outLast;

  int checks = 0;
  int errors = 0;
  int curLen = 0;
  int lastMsgLen = 0;
  bit bpOn = 1'b0;
  logic [9:0] expQ[$];   // {first, last, data}
  logic [7:0] mdl[$];

  always #5 clk = ~clk;

  logbuf_capture #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NEWLINE(10)) i_logbuf_capture (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outFirst(outFirst), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // model: push a finished message into the scoreboard
  task automatic modelAccept(input logic [7:0] b);
    if (b == NL || mdl.size() == DEPTH - 1) begin
      for (int i = 0; i < mdl.size(); i++)
        expQ.push_back({(i == 0), 1'b0, mdl[i]});
      expQ.push_back({(mdl.size() == 0), 1'b1, 8'h00});
      mdl.delete();
    end else begin
      mdl.push_back(b);
    end
  endtask

  // driver: called at a negedge, returns at a negedge after acceptance
  task automatic sendByte(input logic [7:0] b);
    bit rdy;
    inValid = 1'b1;
    inData  = b;
    forever begin
      rdy = inReady;
      if (rdy) modelAccept(b);
      @(negedge clk);
      if (rdy) break;
    end
    inValid = 1'b0;
  endtask

  task automatic sendLine(input int n, input int seed);
    for (int i = 0; i < n; i++) sendByte(8'h41 + 8'((i + seed) % 26));
    sendByte(NL);
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 2000; i++) begin
      if (expQ.size() == 0 && !outValid) break;
      @(negedge clk);
    end
    check(expQ.size() == 0, "R9", "drain pending", expQ.size(), 0);
  endtask

  // sink backpressure pattern
  initial begin
    logic [4:0] lfsr = 5'h13;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      outReady = bpOn ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic [9:0] e;
    bit stalled = 1'b0;
    logic [9:0] held = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst) begin
        stalled = 1'b0;
        curLen = 0;
      end else begin
        if (outValid && inReady)
          check(1'b0, "R7", "inReady high while streaming", 1, 0);
        if (stalled)
          check(outValid && {outFirst, outLast, outData} == held, "R6",
                "held output", {outValid, outFirst, outLast, outData}, {1'b1, held});
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R2", "unexpected byte", outData, 0);
          end else begin
            e = expQ.pop_front();
            check({outFirst, outLast, outData} == e, e[8] ? "R5" : "R2",
                  "output byte", {outFirst, outLast, outData}, e);
          end
          curLen++;
          if (outLast) begin
            lastMsgLen = curLen;
            curLen = 0;
          end
        end
        stalled = outValid && !outReady;
        held = {outFirst, outLast, outData};
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "R9", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && inReady, "R1", "reset outputs", {outValid, inReady}, 2'b01);
    rst = 1'b0;
    @(negedge clk);

    // R3: simple line, R1 offset starts at zero
    sendLine(2, 7);
    waitDrain();
    check(lastMsgLen == 3, "R3", "line length", lastMsgLen, 3);

    // R8: newline at offset zero
    sendByte(NL);
    waitDrain();
    check(lastMsgLen == 1, "R8", "empty message length", lastMsgLen, 1);

    // R4: full buffer, overflow byte discarded
    for (int i = 0; i < DEPTH - 1; i++) sendByte(8'h61 + 8'(i));
    sendByte(8'h5A);
    waitDrain();
    check(lastMsgLen == DEPTH, "R4", "full message length", lastMsgLen, DEPTH);

    // R9: next line starts from offset zero
    sendLine(1, 3);
    waitDrain();
    check(lastMsgLen == 2, "R9", "post-flush length", lastMsgLen, 2);

    // R6/R7: backpressure, writer keeps sending during streaming
    bpOn = 1'b1;
    sendLine(5, 1);
    sendLine(7, 9);
    sendLine(0, 0);
    sendLine(DEPTH + 2, 4);
    waitDrain();
    sendByte(8'h51);
    sendByte(NL);
    waitDrain();
    check(lastMsgLen == 2, "R7", "held byte delivered", lastMsgLen, 2);
    bpOn = 1'b0;

    // R10: reset during a flush
    sendLine(10, 2);
    bpOn = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid, "R10", "streaming before reset", outValid, 1);
    rst = 1'b1;
    expQ.delete();
    mdl.delete();
    @(negedge clk);
    check(!outValid && inReady, "R10", "flush aborted", {outValid, inReady}, 2'b01);
    rst = 1'b0;
    bpOn = 1'b0;
    @(negedge clk);
    sendLine(2, 11);
    waitDrain();
    check(lastMsgLen == 3, "R10", "offset cleared by reset", lastMsgLen, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule